// File: doc/BRIEF.md
# CCD Line-Binning Clock Sequencer

This block drives the timing pins of a full-frame-transfer CCD whose vertical and horizontal shift registers each use two clock phases, operated so that every row of a frame is summed into the horizontal register before readout. A one-cycle `start` launches a frame. The frame runs through four named states in a fixed order: `ST_INTEG` (exposure, shutter requested open), `ST_VBIN` (all rows binned into the horizontal register), `ST_GAP` (settling time after the transfer gate closes) and `ST_HREAD` (every horizontal cell shifted out). The state then returns to `ST_IDLE`.

The transitions are as follows. `ST_IDLE` goes to `ST_INTEG` on `start`. `ST_INTEG` goes to `ST_VBIN` when the exposure count expires. `ST_VBIN` goes to `ST_GAP` at the end of the final vertical cycle. `ST_GAP` goes to `ST_HREAD` when the gap count expires. `ST_HREAD` goes to `ST_IDLE` at the end of the final horizontal cycle. Every duration is a count of master clocks taken from an input port. The pulse widths, the phase overlap, the exposure and the settling gap can therefore be tuned to the sensor's minimums at any clock rate. The transfer gate follows the second vertical phase. The summing gate follows the second horizontal phase. A reset-gate pulse opens each pixel. A framing strobe marks the active pixels between the leading and trailing dummy cells.

The timing inputs must hold steady while `busy` is high. `v_overlap` must be below `v_half`, `h_overlap` must be below `h_half`, and `rg_width` must not exceed `2*h_half`.

Top module: `ccd_binning_timer`

## Requirements
- R1: While `busy` is low, every clock, gate and strobe output is low. This holds after reset as well as between frames.
- R2: `start` sampled while idle raises `busy` and `shutter_req` on the next clock. `shutter_req` stays high for exactly `integ_cycles` clocks, with 0 treated as 1. No register clock moves while it is high.
- R3: Binning issues 128 vertical cycles, each `2*v_half` clocks long. `vclk1` is high for the first `v_half+v_overlap` clocks of a cycle and `vclk2` for the last `v_half` clocks, so the two phases overlap for `v_overlap` clocks and are never both low during binning.
- R4: `xfer_gate` carries the same waveform as `vclk2` on every clock.
- R5: After `xfer_gate` falls at the end of binning, all register clocks stay low for exactly `gap_cycles` clocks (0 treated as 1) before `hclk1` first rises.
- R6: Readout issues 1044 horizontal cycles, each `2*h_half` clocks long, with `hclk1` high for the first `h_half+h_overlap` clocks and `hclk2` high for the last `h_half` clocks. `sum_gate` equals `hclk2`.
- R7: `rst_gate` is high for the first `rg_width` clocks of every horizontal cycle and low otherwise.
- R8: Horizontal cycles are numbered from 0. `pix_valid` is high through all of cycles 10 to 1033 (1024 active pixels) and low through cycles 0 to 9 and 1034 to 1043 (10 leading and 10 trailing dummy cells).
- R9: `done` is a single-clock pulse in the final clock of horizontal cycle 1043. `busy` falls on the following clock.
- R10: A `start` sampled while `busy` is high, including in the clock where `done` is high, has no effect: the frame in progress continues unchanged and no new frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame launch pulse |
| integ_cycles | input | IW (20) | Exposure length in clocks |
| gap_cycles | input | IW (20) | Clocks from transfer-gate fall to first horizontal clock |
| v_half | input | HW (10) | Half period of a vertical cycle in clocks |
| v_overlap | input | HW (10) | Clocks both vertical phases are high together |
| h_half | input | HW (10) | Half period of a horizontal cycle in clocks |
| h_overlap | input | HW (10) | Clocks both horizontal phases are high together |
| rg_width | input | HW (10) | Reset-gate pulse width in clocks |
| vclk1 | output | 1 | Vertical phase 1 |
| vclk2 | output | 1 | Vertical phase 2 |
| xfer_gate | output | 1 | Transfer gate, same as vertical phase 2 |
| hclk1 | output | 1 | Horizontal phase 1 |
| hclk2 | output | 1 | Horizontal phase 2 |
| sum_gate | output | 1 | Summing gate, same as horizontal phase 2 |
| rst_gate | output | 1 | Per-pixel reset-gate pulse |
| pix_valid | output | 1 | High during active-pixel cycles |
| shutter_req | output | 1 | Shutter open request during exposure |
| busy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |

## Verification
A wrong tick or cycle count shows at the ports on the very clock it goes wrong. A phase edge moves, a cycle stretches, or the `pix_valid` window shifts by one whole horizontal cycle, because every output is decoded from the counters without further registers. A wrong state shows just as quickly as clocks during the shutter window or clocks that stop early. The check runs on every clock, so a single misplaced edge is caught within that clock. Restart pulses that arrive mid-binning and in the `done` clock show whether an ignored start leaves any trace in the waveforms.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INTEG = 3'd1,
        ST_VBIN  = 3'd2,
        ST_GAP   = 3'd3,
        ST_HREAD = 3'd4
    } tg_state_t;
endpackage

// File: rtl/cycle_ctr.sv
// Clock-tick and cycle-index counter shared by both register sequencers.
module cycle_ctr #(
    parameter int TW = 11,
    parameter int KW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          wrap,
    input  logic          halt,
    output logic          active,
    output logic [TW-1:0] tick,
    output logic [KW-1:0] idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            tick   <= '0;
            idx    <= '0;
        end else if (!active) begin
            if (launch) begin
                active <= 1'b1;
                tick   <= '0;
                idx    <= '0;
            end
        end else if (halt) begin
            active <= 1'b0;
            tick   <= '0;
            idx    <= '0;
        end else if (wrap) begin
            tick <= '0;
            idx  <= idx + 1'b1;
        end else begin
            tick <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/phase_decode.sv
// Two-phase waveform decode: phase 1 leads, phase 2 trails, overlap at the phase-1 fall.
module phase_decode #(
    parameter int HW   = 10,
    parameter int KW   = 11,
    parameter int NCYC = 1044
) (
    input  logic          active,
    input  logic [HW:0]   tick,
    input  logic [KW-1:0] idx,
    input  logic [HW-1:0] half,
    input  logic [HW-1:0] ovl,
    output logic          ph1,
    output logic          ph2,
    output logic          wrap,
    output logic          last
);
    localparam logic [KW-1:0] LAST_IDX = KW'(NCYC - 1);

    logic [HW:0] per_end;
    logic [HW:0] ph1_end;

    always_comb begin
        per_end = {half, 1'b0} - 1'b1;
        ph1_end = {1'b0, half} + {1'b0, ovl};
        ph1     = active && (tick < ph1_end);
        ph2     = active && (tick >= {1'b0, half});
        wrap    = active && (tick == per_end);
        last    = wrap && (idx == LAST_IDX);
    end
endmodule

// File: rtl/pixel_framer.sv
// Reset-gate pulse at each pixel start and the active-pixel window.
module pixel_framer #(
    parameter int HW     = 10,
    parameter int KW     = 11,
    parameter int LEAD   = 10,
    parameter int ACTIVE = 1024
) (
    input  logic          active,
    input  logic [HW:0]   tick,
    input  logic [KW-1:0] idx,
    input  logic [HW-1:0] rg_width,
    output logic          rg,
    output logic          valid
);
    localparam logic [KW-1:0] FIRST_ACT = KW'(LEAD);
    localparam logic [KW-1:0] END_ACT   = KW'(LEAD + ACTIVE);

    always_comb begin
        rg    = active && (tick < {1'b0, rg_width});
        valid = active && (idx >= FIRST_ACT) && (idx < END_ACT);
    end
endmodule

// File: rtl/ccd_binning_timer.sv
module ccd_binning_timer
    import ccd_tg_pkg::*;
#(
    parameter int IW      = 20,
    parameter int HW      = 10,
    parameter int V_ROWS  = 128,
    parameter int H_CELLS = 1044,
    parameter int LEAD    = 10,
    parameter int ACTIVE  = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] integ_cycles,
    input  logic [IW-1:0] gap_cycles,
    input  logic [HW-1:0] v_half,
    input  logic [HW-1:0] v_overlap,
    input  logic [HW-1:0] h_half,
    input  logic [HW-1:0] h_overlap,
    input  logic [HW-1:0] rg_width,
    output logic          vclk1,
    output logic          vclk2,
    output logic          xfer_gate,
    output logic          hclk1,
    output logic          hclk2,
    output logic          sum_gate,
    output logic          rst_gate,
    output logic          pix_valid,
    output logic          shutter_req,
    output logic          busy,
    output logic          done
);
    localparam int VKW = $clog2(V_ROWS);
    localparam int HKW = $clog2(H_CELLS);

    tg_state_t state, nxt;
    logic [IW-1:0] cnt;
    logic          integ_hit, gap_hit;
    logic          v_launch, h_launch;

    logic           v_active, v_wrap, v_last, v_ph1, v_ph2;
    logic [HW:0]    v_tick;
    logic [VKW-1:0] v_idx;
    logic           h_active, h_wrap, h_last, h_ph1, h_ph2, h_rg, h_valid;
    logic [HW:0]    h_tick;
    logic [HKW-1:0] h_idx;

    // Count expiry: a programmed zero behaves as one clock.
    always_comb begin
        integ_hit = ({1'b0, cnt} + 1'b1) >= {1'b0, integ_cycles};
        gap_hit   = ({1'b0, cnt} + 1'b1) >= {1'b0, gap_cycles};
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)     nxt = ST_INTEG;
            ST_INTEG: if (integ_hit) nxt = ST_VBIN;
            ST_VBIN:  if (v_last)    nxt = ST_GAP;
            ST_GAP:   if (gap_hit)   nxt = ST_HREAD;
            ST_HREAD: if (h_last)    nxt = ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (nxt != state) begin
            cnt <= '0;
        end else if (state == ST_INTEG || state == ST_GAP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign v_launch = (state == ST_INTEG) && integ_hit;
    assign h_launch = (state == ST_GAP) && gap_hit;

    cycle_ctr #(.TW(HW + 1), .KW(VKW)) u_vctr (
        .clk(clk), .rst_n(rst_n), .launch(v_launch), .wrap(v_wrap), .halt(v_last),
        .active(v_active), .tick(v_tick), .idx(v_idx)
    );

    phase_decode #(.HW(HW), .KW(VKW), .NCYC(V_ROWS)) u_vdec (
        .active(v_active), .tick(v_tick), .idx(v_idx), .half(v_half), .ovl(v_overlap),
        .ph1(v_ph1), .ph2(v_ph2), .wrap(v_wrap), .last(v_last)
    );

    cycle_ctr #(.TW(HW + 1), .KW(HKW)) u_hctr (
        .clk(clk), .rst_n(rst_n), .launch(h_launch), .wrap(h_wrap), .halt(h_last),
        .active(h_active), .tick(h_tick), .idx(h_idx)
    );

    phase_decode #(.HW(HW), .KW(HKW), .NCYC(H_CELLS)) u_hdec (
        .active(h_active), .tick(h_tick), .idx(h_idx), .half(h_half), .ovl(h_overlap),
        .ph1(h_ph1), .ph2(h_ph2), .wrap(h_wrap), .last(h_last)
    );

    pixel_framer #(.HW(HW), .KW(HKW), .LEAD(LEAD), .ACTIVE(ACTIVE)) u_frame (
        .active(h_active), .tick(h_tick), .idx(h_idx), .rg_width(rg_width),
        .rg(h_rg), .valid(h_valid)
    );

    always_comb begin
        shutter_req = (state == ST_INTEG);
        busy        = (state != ST_IDLE);
        done        = (state == ST_HREAD) && h_last;
        vclk1       = v_ph1;
        vclk2       = v_ph2;
        xfer_gate   = v_ph2;
        hclk1       = h_ph1;
        hclk2       = h_ph2;
        sum_gate    = h_ph2;
        rst_gate    = h_rg;
        pix_valid   = h_valid;
    end
endmodule

// File: rtl/ccd_tg_checker.sv
module ccd_tg_checker
    import ccd_tg_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      start,
    input logic      vclk1,
    input logic      vclk2,
    input logic      xfer_gate,
    input logic      hclk1,
    input logic      hclk2,
    input logic      rst_gate,
    input logic      pix_valid,
    input logic      shutter_req,
    input logic      busy,
    input logic      done,
    input tg_state_t state
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(vclk1 || vclk2 || hclk1 || hclk2 || rst_gate || pix_valid || done)); // R1
    AST_SHUTTER_CLOCKS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        shutter_req |-> !(vclk1 || vclk2 || hclk1 || hclk2 || rst_gate)); // R2
    AST_VBIN_PHASES_COVER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VBIN) |-> (vclk1 || vclk2)); // R3
    AST_NO_H_WHILE_V: assert property (@(posedge clk) disable iff (!rst_n)
        (vclk1 || vclk2) |-> !(hclk1 || hclk2)); // R5
    AST_TG_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_gate) |-> !hclk1); // R5
    AST_RG_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_gate |-> (state == ST_HREAD)); // R7
    AST_VALID_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ((state == ST_HREAD) && (hclk1 || hclk2))); // R8
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy); // R10
    AST_NO_REINTEG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !shutter_req) |=> !shutter_req); // R10
endmodule

bind ccd_binning_timer ccd_tg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .vclk1(vclk1), .vclk2(vclk2), .xfer_gate(xfer_gate),
    .hclk1(hclk1), .hclk2(hclk2), .rst_gate(rst_gate),
    .pix_valid(pix_valid), .shutter_req(shutter_req),
    .busy(busy), .done(done), .state(state)
);

// File: tb/ccd_binning_timer_bench.sv
module ccd_binning_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int ROWS       = 128;
    localparam int CELLS      = 1044;
    localparam int LEADN      = 10;
    localparam int ACTN       = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] integ_cycles = '0;
    logic [19:0] gap_cycles = '0;
    logic [9:0]  v_half = 10'd1;
    logic [9:0]  v_overlap = '0;
    logic [9:0]  h_half = 10'd1;
    logic [9:0]  h_overlap = '0;
    logic [9:0]  rg_width = '0;
    logic vclk1, vclk2, xfer_gate, hclk1, hclk2, sum_gate, rst_gate;
    logic pix_valid, shutter_req, busy, done;

    int n_checks = 0;
    int n_fails  = 0;
    int n_prints = 0;
    int cyc      = 0;
    bit ended    = 1'b0;

    // Bit order: busy shutter vclk1 vclk2 xfer hclk1 hclk2 sum rst valid done
    typedef struct {
        logic [10:0] v;
        string       tag;
    } exp_t;
    exp_t sb[$];

    ccd_binning_timer u_ccd_binning_timer (
        .clk(clk), .rst_n(rst_n), .start(start),
        .integ_cycles(integ_cycles), .gap_cycles(gap_cycles),
        .v_half(v_half), .v_overlap(v_overlap),
        .h_half(h_half), .h_overlap(h_overlap), .rg_width(rg_width),
        .vclk1(vclk1), .vclk2(vclk2), .xfer_gate(xfer_gate),
        .hclk1(hclk1), .hclk2(hclk2), .sum_gate(sum_gate), .rst_gate(rst_gate),
        .pix_valid(pix_valid), .shutter_req(shutter_req), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string bit_req(int b);
        case (b)
            10: return "R9";
            9:  return "R2";
            8, 7: return "R3";
            6:  return "R4";
            5, 4, 3: return "R6";
            2:  return "R7";
            1:  return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [10:0] observed();
        return {busy, shutter_req, vclk1, vclk2, xfer_gate, hclk1, hclk2,
                sum_gate, rst_gate, pix_valid, done};
    endfunction

    task automatic push(logic [10:0] v, string tag);
        exp_t e;
        e.v   = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares one expected item per clock, sampled at the falling edge.
    always @(negedge clk) begin
        if (!ended && sb.size() > 0) begin
            exp_t e;
            logic [10:0] got;
            e   = sb.pop_front();
            got = observed();
            n_checks++;
            if (got !== e.v) begin
                n_fails++;
                if (n_prints < 20) begin
                    int fb;
                    fb = 0;
                    for (int b = 0; b < 11; b++) if (got[b] !== e.v[b]) fb = b;
                    n_prints++;
                    $display("FAIL %s at cycle %0d: outputs %b expected %b",
                             (e.tag != "") ? e.tag : bit_req(fb), cyc, got, e.v);
                end
            end
        end
    end

    task automatic finish_run();
        ended = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !ended) begin
            n_fails++;
            $display("FAIL watchdog: run exceeded %0d cycles, expected completion", WATCHDOG);
            finish_run();
        end
    end

    // Driver: programs a frame, pulses start and pushes the expected trace.
    task automatic run_frame(int integ, int vh, int vo, int hh, int ho, int rgw,
                             int gap, int restart_at, string ovr);
        int il, gl, flen;
        string t3, t5;
        il = (integ == 0) ? 1 : integ;
        gl = (gap == 0) ? 1 : gap;
        flen = il + ROWS * 2 * vh + gl + CELLS * 2 * hh;
        t3 = (ovr != "") ? ovr : "";
        t5 = (ovr != "") ? ovr : "R5";
        @(posedge clk);
        #1;
        integ_cycles = 20'(integ);
        gap_cycles   = 20'(gap);
        v_half       = 10'(vh);
        v_overlap    = 10'(vo);
        h_half       = 10'(hh);
        h_overlap    = 10'(ho);
        rg_width     = 10'(rgw);
        start        = 1'b1;
        push(11'b0, "R2");
        // R2: exposure window
        for (int i = 0; i < il; i++) push(11'b110_0000_0000, (ovr != "") ? ovr : "R2");
        // R3 R4: binning cycles
        for (int r = 0; r < ROWS; r++)
            for (int t = 0; t < 2 * vh; t++) begin
                logic p1, p2;
                p1 = (t < vh + vo);
                p2 = (t >= vh);
                push({1'b1, 1'b0, p1, p2, p2, 6'b0}, t3);
            end
        // R5: settling gap
        for (int g = 0; g < gl; g++) push(11'b100_0000_0000, t5);
        // R6 R7 R8 R9: readout cycles
        for (int k = 0; k < CELLS; k++)
            for (int t = 0; t < 2 * hh; t++) begin
                logic p1, p2, rg, vl, dn;
                p1 = (t < hh + ho);
                p2 = (t >= hh);
                rg = (t < rgw);
                vl = (k >= LEADN) && (k < LEADN + ACTN);
                dn = (k == CELLS - 1) && (t == 2 * hh - 1);
                push({1'b1, 1'b0, 1'b0, 1'b0, 1'b0, p1, p2, p2, rg, vl, dn}, t3);
            end
        // R9 R10: idle after the frame
        push(11'b0, (ovr != "") ? ovr : "R9");
        push(11'b0, (ovr != "") ? ovr : "R9");
        @(posedge clk);
        #1;
        start = 1'b0;
        if (restart_at > 0 && restart_at < flen) begin
            repeat (restart_at) @(posedge clk);
            #1;
            start = 1'b1;
            @(posedge clk);
            #1;
            start = 1'b0;
        end
        while (sb.size() != 0) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        n_checks++;
        if (observed() !== 11'b0) begin
            n_fails++;
            $display("FAIL R1 in reset: outputs %b expected %b", observed(), 11'b0);
        end
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) push(11'b0, "R1");
        while (sb.size() != 0) @(posedge clk);
        #1;
        // Frame A: typical settings
        run_frame(5, 3, 1, 2, 1, 1, 4, 0, "");
        // Frame B: zero exposure and gap counts, wide overlaps and reset pulse
        run_frame(0, 4, 3, 3, 2, 5, 0, 0, "");
        // Frame C: R10 restart pulse during binning
        run_frame(7, 2, 1, 1, 0, 1, 3, 60, "R10");
        // Frame D: R10 restart pulse in the done clock (frame length 4953, minus one)
        run_frame(5, 3, 1, 2, 1, 1, 4, 4952, "R10");
        // R1: idle between frames stays quiet
        for (int i = 0; i < 3; i++) push(11'b0, "R1");
        while (sb.size() != 0) @(posedge clk);
        #1;
        finish_run();
    end
endmodule